// File: doc/BRIEF.md
# Big-Endian Word/Byte Load-Store Aligner

This block connects a 32-bit register datapath to a word-wide data memory. It serves four kinds of access: word load, word store, byte load and byte store. The memory address is computed from a base register value and a signed 16-bit displacement. The block checks that word accesses are aligned. It selects byte lanes using big-endian numbering, so byte offset 0 is the most significant byte of a word.

Loads take their result from the memory combinationally in the same cycle. Stores drive a per-lane enable mask and lane-aligned write data, and they commit on the next rising clock edge. The data memory is a behavioural array inside the block, split into one narrow array per byte lane. The word index is taken from the address bits above the byte offset, modulo the memory depth.

Top module: `ldst_align_unit`

## Requirements
- R1: `eff_addr` equals `base_val` plus `imm_off` sign-extended to 32 bits, so a displacement with bit 15 set moves the address downward.
- R2: A word load (`req_store`=0, `req_byte`=0) at an address with bits 1:0 equal to 00 returns, in the same cycle, the word most recently stored at that word index.
- R3: A byte load picks the byte by address bits 1:0 in big-endian order: 0 selects stored bits 31:24, 1 selects 23:16, 2 selects 15:8 and 3 selects 7:0. The byte appears in `load_val[7:0]`, and its bit 7 is copied into `load_val[31:8]`.
- R4: A valid aligned word store drives `byte_en`=4'b1111 and `wr_data`=`store_val`, and the whole word is written at the next rising clock edge.
- R5: A byte store drives exactly one `byte_en` bit. Offset 0 gives 4'b1000, 1 gives 4'b0100, 2 gives 4'b0010 and 3 gives 4'b0001. `wr_data` carries `store_val[7:0]` copied into all four lanes. Only that byte of the memory word changes, and the other three bytes keep their values.
- R6: A word access whose address bits 1:0 are not 00 raises `misaligned`, drives `byte_en` to 0, writes nothing, and returns `load_val`=0.
- R7: A byte access never raises `misaligned`, whatever the address.
- R8: When `req_valid` is low, or the request is a load, `byte_en` is 0 and memory is not modified. `load_val` is 0 unless a valid, aligned load is in progress.
- R9: While `rst` is high, no store commits to memory.
- R10: The memory word index is `eff_addr[2 +: log2(DEPTH_WORDS)]`. Addresses that differ only in higher bits alias to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks memory writes |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| base_val | input | 32 | Base register value |
| imm_off | input | 16 | Signed displacement field |
| store_val | input | 32 | Source register value for stores |
| load_val | output | 32 | Load result for the destination register |
| eff_addr | output | 32 | Effective byte address |
| byte_en | output | 4 | Per-lane write enable, bit 3 = most significant byte |
| wr_data | output | 32 | Lane-aligned write data |
| misaligned | output | 1 | Word access with a non-zero byte offset |

## Verification
The bench builds the block with `DEPTH_WORDS`=16, a 64-byte memory. At that depth every word can be written to a known value right after reset. It also means that addresses 64 bytes apart alias, so the index wrap of R10 can be reached with small displacements. Base values far above the memory size, combined with negative displacements, exercise the full 32-bit address sum while still landing on real words. A byte-level reference copy in the bench checks the untouched lanes after each partial store.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  // Big-endian lane order: byte offset 0 drives the top enable bit.
  function automatic logic [LANES-1:0] lane_mask(input logic [LANE_W-1:0] ofs);
    logic [LANES-1:0] m;
    m = '0;
    m[LANES-1-ofs] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              is_byte,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr,
  output logic [LANE_W-1:0] lane,
  output logic              misaligned
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  assign off_ext    = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign addr       = base + off_ext;
  assign lane       = addr[LANE_W-1:0];
  assign misaligned = valid && !is_byte && (lane != '0);

  // R7: a byte access is never flagged.
  p_byte_never_mis_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && is_byte) |-> !misaligned);
  // R6: the flag only ever appears on a word access.
  p_mis_word_only_r6: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (valid && !is_byte));
endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              is_store,
  input  logic              is_byte,
  input  logic              misaligned,
  input  logic [LANE_W-1:0] lane,
  input  logic [WORD_W-1:0] store_val,
  input  logic [WORD_W-1:0] rd_word,
  output logic [LANES-1:0]  byte_en,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] load_val
);
  logic              do_store;
  logic              do_load;
  logic [BYTE_W-1:0] sel_byte;

  assign do_store = valid && is_store && !misaligned;
  assign do_load  = valid && !is_store && !misaligned;

  always_comb begin
    byte_en = '0;
    if (do_store) byte_en = is_byte ? lane_mask(lane) : '1;
  end

  assign wr_data = is_byte ? {LANES{store_val[BYTE_W-1:0]}} : store_val;

  // Big-endian extraction: offset 0 is the top byte of the word.
  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LANE_W'(i)) sel_byte = rd_word[(LANES-1-i)*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    load_val = '0;
    if (do_load) begin
      load_val = is_byte ? {{(WORD_W-BYTE_W){sel_byte[BYTE_W-1]}}, sel_byte} : rd_word;
    end
  end

  // R5: a byte store opens exactly one lane.
  p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && is_store && is_byte) |-> ($countones(byte_en) == 1));
  // R6: a misaligned access never writes.
  p_mis_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (byte_en == '0));
  // R8: loads and idle cycles leave the memory alone.
  p_load_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !(valid && is_store) |-> (byte_en == '0));
  // R8: no load data outside a valid load.
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (load_val == '0));
endmodule

// File: rtl/lsu_byte_mem.sv
module lsu_byte_mem
  import lsu_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  localparam int IDX_W = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  byte_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH_WORDS];

    always_ff @(posedge clk) begin
      if (!rst && byte_en[k]) lane_mem[idx] <= wdata[k*BYTE_W +: BYTE_W];
    end

    assign rd_word[k*BYTE_W +: BYTE_W] = lane_mem[idx];

    // R4: an enabled lane holds the written byte after the edge.
    p_lane_written_r4: assert property (@(posedge clk) disable iff (rst)
      byte_en[k] |=> (lane_mem[$past(idx)] == $past(wdata[k*BYTE_W +: BYTE_W])));
    // R5: a lane without enable keeps its byte at a fixed index.
    p_lane_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!byte_en[k] ##1 $stable(idx)) |-> $stable(rd_word[k*BYTE_W +: BYTE_W]));
  end
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import lsu_pkg::*;
#(
  parameter int DEPTH_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic        req_byte,
  input  logic [31:0] base_val,
  input  logic [15:0] imm_off,
  input  logic [31:0] store_val,
  output logic [31:0] load_val,
  output logic [31:0] eff_addr,
  output logic [3:0]  byte_en,
  output logic [31:0] wr_data,
  output logic        misaligned
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);

  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] rd_word;
  logic [IDX_W-1:0]  word_idx;

  lsu_addr_gen #(.ADDR_W(32), .OFF_W(16)) u_addr (
    .clk(clk), .rst(rst), .valid(req_valid), .is_byte(req_byte),
    .base(base_val), .offset(imm_off), .addr(eff_addr), .lane(lane),
    .misaligned(misaligned)
  );

  assign word_idx = eff_addr[LANE_W +: IDX_W];

  lsu_lane_ctrl u_lane (
    .clk(clk), .rst(rst), .valid(req_valid), .is_store(req_store),
    .is_byte(req_byte), .misaligned(misaligned), .lane(lane),
    .store_val(store_val), .rd_word(rd_word), .byte_en(byte_en),
    .wr_data(wr_data), .load_val(load_val)
  );

  lsu_byte_mem #(.DEPTH_WORDS(DEPTH_WORDS)) u_mem (
    .clk(clk), .rst(rst), .byte_en(byte_en), .idx(word_idx),
    .wdata(wr_data), .rd_word(rd_word)
  );

  // R1: the address follows the sign-extended displacement.
  p_addr_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && imm_off[15]) |-> (eff_addr == base_val - (32'h10000 - {16'h0, imm_off})));
endmodule

// File: tb/tb_ldst_align_unit.sv
`timescale 1ns/1ps
module tb_ldst_align_unit;
  localparam int DEPTH = 16;
  localparam int IDXW  = $clog2(DEPTH);

  typedef struct {
    logic        st;
    logic        mis;
    logic [3:0]  be;
    logic [31:0] ea;
    logic [31:0] ld;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0;
  logic [31:0] base_val = '0, store_val = '0;
  logic [15:0] imm_off = '0;
  logic [31:0] load_val, eff_addr, wr_data;
  logic [3:0]  byte_en;
  logic        misaligned;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];
  logic [7:0] ref_mem [DEPTH*4];

  always #2.5 clk = ~clk;

  ldst_align_unit #(.DEPTH_WORDS(DEPTH)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_byte(req_byte), .base_val(base_val), .imm_off(imm_off),
    .store_val(store_val), .load_val(load_val), .eff_addr(eff_addr),
    .byte_en(byte_en), .wr_data(wr_data), .misaligned(misaligned)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one request and pushes the expected result.
  task automatic op(input logic st, input logic by, input logic [31:0] base,
                    input logic [15:0] off, input logic [31:0] sv, input string tag);
    exp_t e;
    logic [31:0] ea;
    logic [IDXW-1:0] idx;
    logic [1:0] ln;
    logic [7:0] b;
    @(posedge clk); #1;
    req_valid = 1; req_store = st; req_byte = by;
    base_val = base; imm_off = off; store_val = sv;
    ea  = base + {{16{off[15]}}, off};
    idx = ea[2 +: IDXW];
    ln  = ea[1:0];
    e.tag = tag; e.st = st; e.ea = ea;
    e.mis = !by && (ln != 2'd0);
    e.be  = (st && !e.mis) ? (by ? (4'b1000 >> ln) : 4'b1111) : 4'b0000;
    e.wd  = by ? {4{sv[7:0]}} : sv;
    b = ref_mem[idx*4 + ln];
    if (st || e.mis) e.ld = '0;
    else if (by)     e.ld = {{24{b[7]}}, b};
    else e.ld = {ref_mem[idx*4], ref_mem[idx*4+1], ref_mem[idx*4+2], ref_mem[idx*4+3]};
    q.push_back(e);
    if (st && !e.mis) begin
      if (by) ref_mem[idx*4 + ln] = sv[7:0];
      else for (int i = 0; i < 4; i++) ref_mem[idx*4 + i] = sv[31-8*i -: 8];
    end
  endtask

  // Monitor: compares the outputs away from the clock edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " addr"}, eff_addr, e.ea);
      chk({e.tag, " misaligned"}, {31'd0, misaligned}, {31'd0, e.mis});
      chk({e.tag, " byte_en"}, {28'd0, byte_en}, {28'd0, e.be});
      if (e.st && !e.mis) chk({e.tag, " wr_data"}, wr_data, e.wd);
      if (!e.st) chk({e.tag, " load_val"}, load_val, e.ld);
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 0; req_store = 0; req_byte = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset state with no request (R8)
    chk("R8 reset byte_en", {28'd0, byte_en}, 32'd0);
    chk("R8 reset misaligned", {31'd0, misaligned}, 32'd0);
    chk("R8 reset load_val", load_val, 32'd0);
    rst = 0;
    // R4: fill every word with a known pattern
    for (int w = 0; w < DEPTH; w++) op(1, 0, 32'h0, 16'(w*4), 32'hA5000000 | w, "R4 fill");
    op(1, 0, 32'h1000, 16'h0008, 32'h11223344, "R4 word store");
    op(0, 0, 32'h1000, 16'h0008, 0, "R2 word load");
    // R3: byte lanes in big-endian order
    for (int l = 0; l < 4; l++) op(0, 1, 32'h1008, 16'(l), 0, "R3 byte load");
    op(1, 0, 32'h0, 16'h000C, 32'h80FF7F01, "R4 sign pattern");
    for (int l = 0; l < 4; l++) op(0, 1, 32'h000C, 16'(l), 0, "R3 sign extend");
    // R1: negative displacement and large base
    op(0, 0, 32'h1010, 16'hFFF8, 0, "R1 negative offset");
    op(0, 1, 32'hFFFF_0003, 16'h0010, 0, "R1 large base");
    // R5: byte store touches one lane
    op(1, 1, 32'h1008, 16'h0002, 32'hDEADBEAB, "R5 byte store lane2");
    op(0, 0, 32'h1008, 16'h0000, 0, "R5 neighbours kept");
    op(1, 1, 32'h0013, 16'h0000, 32'h0000005A, "R5 R7 byte store lane3");
    op(0, 0, 32'h0010, 16'h0000, 0, "R5 lane3 word");
    op(1, 1, 32'h0014, 16'h0000, 32'h000000C3, "R5 byte store lane0");
    op(0, 0, 32'h0014, 16'h0000, 0, "R5 lane0 word");
    // R6: misaligned word accesses
    op(1, 0, 32'h1008, 16'h0002, 32'hFFFFFFFF, "R6 misaligned store");
    op(0, 0, 32'h1008, 16'h0000, 0, "R6 no write");
    op(0, 0, 32'h1009, 16'h0000, 0, "R6 misaligned load");
    op(0, 1, 32'h1009, 16'h0000, 0, "R7 odd byte load");
    // R10: aliasing across the memory size
    op(1, 0, 32'h0040, 16'h0000, 32'h0BADCAFE, "R10 alias store");
    op(0, 0, 32'h0000, 16'h0000, 0, "R10 alias load");
    idle();
    @(posedge clk); #1;
    // R8: idle cycle keeps load_val and byte_en at zero
    chk("R8 idle byte_en", {28'd0, byte_en}, 32'd0);
    chk("R8 idle load_val", load_val, 32'd0);
    // R9: store under reset must not commit
    rst = 1; req_valid = 1; req_store = 1; req_byte = 0;
    base_val = 32'h8; imm_off = 16'h0; store_val = 32'hCAFEF00D;
    @(posedge clk); #1;
    rst = 0; req_valid = 0; req_store = 0;
    op(0, 0, 32'h8, 16'h0, 0, "R9 reset blocks store");
    idle();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule